// File: doc/BRIEF.md
# Batcher Control Register Front End

This block sits in front of a superframe batcher on a single clock. An AXI4-Lite slave holds the batcher's three runtime limits: the byte threshold, the largest number of subframes per superframe, and the longest idle gap in clocks. It drives them straight to the batcher from registers. The same register space reports a status word, which combines a live idle flag from the batcher with a fixed format version. It also offers two control bits that act on the data path.

The first control bit is a level soft reset, which holds the batcher in reset until software clears it. The second is a drain control. While drain is in force, every inbound beat is accepted and discarded, and nothing is offered downstream. The drain bit that software writes is only sampled at input frame boundaries. A frame that has started is therefore always delivered or always dropped as a whole, and the batcher never sees a partial frame. When drain is off, beats pass straight through with no added latency.

Top module: `batcher_ctrl_front`

## Requirements
- R1: After reset, the threshold, subframe-count and gap outputs hold their reset parameters, and the soft-reset output is 0. Reads of offsets 0x00, 0x04 and 0x08 return those reset values, and reads of 0xF8 and 0xFC return 0.
- R2: A write to 0x00, 0x04 or 0x08 updates the matching output on the write handshake, and later reads return it. Only the low field-width bits are kept (32 for the threshold, 16 for the subframe count, 32 for the gap). Each write handshake is followed by a write response with code OKAY (2'b00).
- R3: A write updates only the byte lanes whose write strobe bit is set. Strobe bit i covers data bits [8i+7:8i].
- R4: Offset 0x0C is read-only. Bit 0 is the live batcher idle input, bits [7:4] are the version parameter, and all other bits are 0. Writes to it change nothing.
- R5: Reads of unmapped offsets return 0 with response OKAY. Writes to unmapped offsets change no register. Read data stays stable while it is not accepted.
- R6: Bit 0 of offset 0xFC drives the soft-reset output as a level. The output changes only on a write handshake, and reads of 0xFC return the bit.
- R7: While drain is in force, the input ready signal is 1 and the output valid signal is 0, so every offered beat is consumed and none reaches the output.
- R8: While drain is not in force, the output carries the input's data, last flag and valid signal unchanged and in order, and input ready follows output ready.
- R9: Bit 0 of offset 0xF8 is the drain request, and reads of 0xF8 return it at once. The request takes effect only when no input frame is open. A change made after the first beat of a frame, and before its last beat, leaves that whole frame handled in its old way and applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Write data |
| s_axil_wstrb | input | 4 | Write byte strobes |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response code |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Read data |
| s_axil_rresp | output | 2 | Read response code |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| in_tdata | input | DATA_W | Inbound beat data |
| in_tlast | input | 1 | Inbound last beat of frame |
| in_tvalid | input | 1 | Inbound beat valid |
| in_tready | output | 1 | Inbound beat ready |
| out_tdata | output | DATA_W | Data toward the batcher |
| out_tlast | output | 1 | Last flag toward the batcher |
| out_tvalid | output | 1 | Valid toward the batcher |
| out_tready | input | 1 | Ready from the batcher |
| cfg_byte_thresh | output | THRESH_W | Superframe byte threshold |
| cfg_max_subframes | output | SUBCNT_W | Subframe count limit |
| cfg_max_gap | output | GAP_W | Idle gap limit in clocks |
| batcher_soft_rst | output | 1 | Level reset to the batcher |
| batcher_idle | input | 1 | Idle flag from the batcher |

## Verification
The hardest case is a drain request that arrives mid-frame, in either direction. A design that switched at once would send the batcher the head of a frame without its tail, or the tail without its head. The bench checks this by expecting every frame to arrive whole or not at all. Byte-strobe writes and over-wide writes to the 16-bit count field are checked; a design that ignored the strobes, or kept the upper bits, would read back the wrong value. Writes to the status word and to unmapped offsets must leave every other register as it was. Downstream backpressure is applied during pass-through, so a design that dropped or repeated beats while ready is low leaves a hole or a duplicate in the expected beat order.

// File: rtl/batcher_ctrl_pkg.sv
package batcher_ctrl_pkg;

  localparam int REG_W   = 32;
  localparam int LANES   = REG_W / 8;

  // Byte offsets of the register words
  localparam logic [7:0] OFS_THRESH = 8'h00;
  localparam logic [7:0] OFS_SUBCNT = 8'h04;
  localparam logic [7:0] OFS_GAP    = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_DRAIN  = 8'hF8;
  localparam logic [7:0] OFS_HOLD   = 8'hFC;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Merge write data into a word lane by lane under the strobes
  function automatic logic [REG_W-1:0] merge_lanes(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] wd,
    input logic [LANES-1:0] st
  );
    logic [REG_W-1:0] res;
    res = cur;
    for (int i = 0; i < LANES; i++) begin
      if (st[i]) res[i*8 +: 8] = wd[i*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/bctl_regbank.sv
module bctl_regbank
  import batcher_ctrl_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          THRESH_W   = 32,
  parameter int          SUBCNT_W   = 16,
  parameter int          GAP_W      = 32,
  parameter logic [31:0] THRESH_RST = 32'h0000_1000,
  parameter logic [31:0] SUBCNT_RST = 32'd32,
  parameter logic [31:0] GAP_RST    = 32'd256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [REG_W-1:0]    wdata,
  input  logic [LANES-1:0]    wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  output logic [THRESH_W-1:0] thresh_q,
  output logic [SUBCNT_W-1:0] subcnt_q,
  output logic [GAP_W-1:0]    gap_q,
  output logic                drain_q,
  output logic                hold_q
);

  localparam int WIDX = ADDR_W - 2;

  logic            bvalid_q;
  logic            wr_go;
  logic [WIDX-1:0] widx;
  logic [REG_W-1:0] drain_word, hold_word;

  // Both channels are taken together once no response is pending
  assign wr_go   = awvalid && wvalid && !bvalid_q;
  assign awready = wr_go;
  assign wready  = wr_go;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;
  assign widx    = awaddr[ADDR_W-1:2];

  assign drain_word = merge_lanes({{(REG_W-1){1'b0}}, drain_q}, wdata, wstrb);
  assign hold_word  = merge_lanes({{(REG_W-1){1'b0}}, hold_q}, wdata, wstrb);

  always_ff @(posedge clk) begin
    if (rst) begin
      bvalid_q <= 1'b0;
      thresh_q <= THRESH_W'(THRESH_RST);
      subcnt_q <= SUBCNT_W'(SUBCNT_RST);
      gap_q    <= GAP_W'(GAP_RST);
      drain_q  <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      if (wr_go) begin
        bvalid_q <= 1'b1;
        if (widx == WIDX'(OFS_THRESH >> 2))
          thresh_q <= THRESH_W'(merge_lanes(REG_W'(thresh_q), wdata, wstrb));
        if (widx == WIDX'(OFS_SUBCNT >> 2))
          subcnt_q <= SUBCNT_W'(merge_lanes(REG_W'(subcnt_q), wdata, wstrb));
        if (widx == WIDX'(OFS_GAP >> 2))
          gap_q <= GAP_W'(merge_lanes(REG_W'(gap_q), wdata, wstrb));
        if (widx == WIDX'(OFS_DRAIN >> 2))
          drain_q <= drain_word[0];
        if (widx == WIDX'(OFS_HOLD >> 2))
          hold_q <= hold_word[0];
      end else if (bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bctl_readmux.sv
module bctl_readmux
  import batcher_ctrl_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         THRESH_W = 32,
  parameter int         SUBCNT_W = 16,
  parameter int         GAP_W    = 32,
  parameter logic [3:0] VERSION  = 4'd2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [REG_W-1:0]    rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  input  logic [THRESH_W-1:0] thresh_q,
  input  logic [SUBCNT_W-1:0] subcnt_q,
  input  logic [GAP_W-1:0]    gap_q,
  input  logic                drain_q,
  input  logic                hold_q,
  input  logic                idle_in
);

  localparam int RIDX = ADDR_W - 2;

  logic             rvalid_q;
  logic [REG_W-1:0] rdata_q;
  logic [REG_W-1:0] rd_word;
  logic [RIDX-1:0]  ridx;

  assign ridx    = araddr[ADDR_W-1:2];
  assign arready = !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  always_comb begin
    rd_word = '0;
    if (ridx == RIDX'(OFS_THRESH >> 2)) rd_word = REG_W'(thresh_q);
    if (ridx == RIDX'(OFS_SUBCNT >> 2)) rd_word = REG_W'(subcnt_q);
    if (ridx == RIDX'(OFS_GAP >> 2))    rd_word = REG_W'(gap_q);
    if (ridx == RIDX'(OFS_STATUS >> 2)) rd_word = {{(REG_W-8){1'b0}}, VERSION, 3'b000, idle_in};
    if (ridx == RIDX'(OFS_DRAIN >> 2))  rd_word = {{(REG_W-1){1'b0}}, drain_q};
    if (ridx == RIDX'(OFS_HOLD >> 2))   rd_word = {{(REG_W-1){1'b0}}, hold_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && !rvalid_q) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bctl_stream_gate.sv
module bctl_stream_gate #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drain_req,
  output logic              drain_active,
  input  logic [DATA_W-1:0] in_tdata,
  input  logic              in_tlast,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic [DATA_W-1:0] out_tdata,
  output logic              out_tlast,
  output logic              out_tvalid,
  input  logic              out_tready
);

  logic frame_open;
  logic accept;
  logic boundary;

  assign in_tready  = drain_active ? 1'b1 : out_tready;
  assign out_tvalid = in_tvalid && !drain_active;
  assign out_tdata  = in_tdata;
  assign out_tlast  = in_tlast;
  assign accept     = in_tvalid && in_tready;

  // Mode may only switch when no frame is open after this cycle
  assign boundary = accept ? in_tlast : !frame_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_open   <= 1'b0;
      drain_active <= 1'b0;
    end else begin
      if (accept) frame_open <= !in_tlast;
      if (boundary) drain_active <= drain_req;
    end
  end

endmodule

// File: rtl/batcher_ctrl_front.sv
module batcher_ctrl_front
  import batcher_ctrl_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 64,
  parameter int          THRESH_W   = 32,
  parameter int          SUBCNT_W   = 16,
  parameter int          GAP_W      = 32,
  parameter logic [31:0] THRESH_RST = 32'h0000_1000,
  parameter logic [31:0] SUBCNT_RST = 32'd32,
  parameter logic [31:0] GAP_RST    = 32'd256,
  parameter logic [3:0]  VERSION    = 4'd2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_axil_awaddr,
  input  logic                s_axil_awvalid,
  output logic                s_axil_awready,
  input  logic [31:0]         s_axil_wdata,
  input  logic [3:0]          s_axil_wstrb,
  input  logic                s_axil_wvalid,
  output logic                s_axil_wready,
  output logic [1:0]          s_axil_bresp,
  output logic                s_axil_bvalid,
  input  logic                s_axil_bready,
  input  logic [ADDR_W-1:0]   s_axil_araddr,
  input  logic                s_axil_arvalid,
  output logic                s_axil_arready,
  output logic [31:0]         s_axil_rdata,
  output logic [1:0]          s_axil_rresp,
  output logic                s_axil_rvalid,
  input  logic                s_axil_rready,
  input  logic [DATA_W-1:0]   in_tdata,
  input  logic                in_tlast,
  input  logic                in_tvalid,
  output logic                in_tready,
  output logic [DATA_W-1:0]   out_tdata,
  output logic                out_tlast,
  output logic                out_tvalid,
  input  logic                out_tready,
  output logic [THRESH_W-1:0] cfg_byte_thresh,
  output logic [SUBCNT_W-1:0] cfg_max_subframes,
  output logic [GAP_W-1:0]    cfg_max_gap,
  output logic                batcher_soft_rst,
  input  logic                batcher_idle
);

  logic drain_q;
  logic drain_active;

  bctl_regbank #(
    .ADDR_W(ADDR_W), .THRESH_W(THRESH_W), .SUBCNT_W(SUBCNT_W), .GAP_W(GAP_W),
    .THRESH_RST(THRESH_RST), .SUBCNT_RST(SUBCNT_RST), .GAP_RST(GAP_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
    .wdata(s_axil_wdata), .wstrb(s_axil_wstrb), .wvalid(s_axil_wvalid),
    .wready(s_axil_wready), .bresp(s_axil_bresp), .bvalid(s_axil_bvalid),
    .bready(s_axil_bready),
    .thresh_q(cfg_byte_thresh), .subcnt_q(cfg_max_subframes), .gap_q(cfg_max_gap),
    .drain_q(drain_q), .hold_q(batcher_soft_rst)
  );

  bctl_readmux #(
    .ADDR_W(ADDR_W), .THRESH_W(THRESH_W), .SUBCNT_W(SUBCNT_W), .GAP_W(GAP_W),
    .VERSION(VERSION)
  ) u_read (
    .clk(clk), .rst(rst),
    .araddr(s_axil_araddr), .arvalid(s_axil_arvalid), .arready(s_axil_arready),
    .rdata(s_axil_rdata), .rresp(s_axil_rresp), .rvalid(s_axil_rvalid),
    .rready(s_axil_rready),
    .thresh_q(cfg_byte_thresh), .subcnt_q(cfg_max_subframes), .gap_q(cfg_max_gap),
    .drain_q(drain_q), .hold_q(batcher_soft_rst), .idle_in(batcher_idle)
  );

  bctl_stream_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst),
    .drain_req(drain_q), .drain_active(drain_active),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid),
    .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tlast(out_tlast), .out_tvalid(out_tvalid),
    .out_tready(out_tready)
  );

endmodule

// File: rtl/bctl_checker.sv
module bctl_checker #(
  parameter int          THRESH_W   = 32,
  parameter int          SUBCNT_W   = 16,
  parameter int          GAP_W      = 32,
  parameter logic [31:0] THRESH_RST = 32'h0000_1000,
  parameter logic [31:0] SUBCNT_RST = 32'd32,
  parameter logic [31:0] GAP_RST    = 32'd256
) (
  input logic                clk,
  input logic                rst,
  input logic                awvalid,
  input logic                awready,
  input logic                wvalid,
  input logic                wready,
  input logic                bvalid,
  input logic [1:0]          bresp,
  input logic                rvalid,
  input logic                rready,
  input logic [31:0]         rdata,
  input logic [1:0]          rresp,
  input logic                in_tvalid,
  input logic                in_tready,
  input logic                in_tlast,
  input logic                drain_active,
  input logic [THRESH_W-1:0] thresh,
  input logic [SUBCNT_W-1:0] subcnt,
  input logic [GAP_W-1:0]    gap,
  input logic                soft_rst
);

  logic wr_fire;
  logic mid_frame;

  assign wr_fire = awvalid && awready && wvalid && wready;

  always_ff @(posedge clk) begin
    if (rst) mid_frame <= 1'b0;
    else if (in_tvalid && in_tready) mid_frame <= !in_tlast;
  end

  // R1
  reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (thresh == THRESH_W'(THRESH_RST) && subcnt == SUBCNT_W'(SUBCNT_RST)
                    && gap == GAP_W'(GAP_RST) && !soft_rst));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_fire) |-> ($stable(thresh) && $stable(subcnt) && $stable(gap)));

  // R2
  wr_resp_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (bvalid && bresp == 2'b00));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  // R5
  rd_okay_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rresp == 2'b00);

  // R6
  soft_rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_fire) |-> $stable(soft_rst));

  // R9
  no_mid_switch_chk: assert property (@(posedge clk) disable iff (rst)
    mid_frame |-> $stable(drain_active));

endmodule

bind batcher_ctrl_front bctl_checker #(
  .THRESH_W(THRESH_W), .SUBCNT_W(SUBCNT_W), .GAP_W(GAP_W),
  .THRESH_RST(THRESH_RST), .SUBCNT_RST(SUBCNT_RST), .GAP_RST(GAP_RST)
) u_bctl_chk (
  .clk(clk), .rst(rst),
  .awvalid(s_axil_awvalid), .awready(s_axil_awready),
  .wvalid(s_axil_wvalid), .wready(s_axil_wready),
  .bvalid(s_axil_bvalid), .bresp(s_axil_bresp),
  .rvalid(s_axil_rvalid), .rready(s_axil_rready),
  .rdata(s_axil_rdata), .rresp(s_axil_rresp),
  .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tlast(in_tlast),
  .drain_active(drain_active),
  .thresh(cfg_byte_thresh), .subcnt(cfg_max_subframes), .gap(cfg_max_gap),
  .soft_rst(batcher_soft_rst)
);

// File: tb/tb_batcher_ctrl_front.sv
`timescale 1ns/1ps
module tb_batcher_ctrl_front;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0;
  logic bready = 1, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [DATA_W-1:0] in_tdata = '0;
  logic in_tlast = 0, in_tvalid = 0, out_tready = 1;
  logic in_tready, out_tlast, out_tvalid;
  logic [DATA_W-1:0] out_tdata;
  logic [31:0] thresh;
  logic [15:0] subcnt;
  logic [31:0] gap;
  logic soft_rst;
  logic idle = 1;

  batcher_ctrl_front dut (
    .clk(clk), .rst(rst),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid),
    .s_axil_wready(wready), .s_axil_bresp(bresp), .s_axil_bvalid(bvalid),
    .s_axil_bready(bready),
    .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
    .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid),
    .s_axil_rready(rready),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid),
    .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tlast(out_tlast), .out_tvalid(out_tvalid),
    .out_tready(out_tready),
    .cfg_byte_thresh(thresh), .cfg_max_subframes(subcnt), .cfg_max_gap(gap),
    .batcher_soft_rst(soft_rst), .batcher_idle(idle)
  );

  int n_run = 0, n_fail = 0;
  logic bp_en = 0;
  int bp_cnt = 0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [DATA_W:0] st_exp_q[$];
  string       st_tag_q[$];

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic axil_write(logic [7:0] a, logic [31:0] d, logic [3:0] s, string tag);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    @(negedge clk); #1;
    chk({tag, " write response"}, {bvalid, bresp}, 3'b100);
  endtask

  // Driver side of the scoreboard: expected read data is queued here
  task automatic axil_read(logic [7:0] a, logic [31:0] exp, string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    @(negedge clk);
    araddr = a; arvalid = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    arvalid = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_beat(logic [DATA_W-1:0] d, logic l, logic drop, string tag);
    if (!drop) begin
      st_exp_q.push_back({l, d});
      st_tag_q.push_back(tag);
    end
    @(negedge clk);
    in_tdata = d; in_tlast = l; in_tvalid = 1;
    #1;
    while (!in_tready) begin @(negedge clk); #1; end
    if (drop) chk({tag, " drop gating"}, {in_tready, out_tvalid}, 2'b10);
    @(posedge clk); #1;
    in_tvalid = 0;
  endtask

  task automatic send_frame(int base, int len, logic drop, string tag);
    for (int i = 0; i < len; i++)
      send_beat(DATA_W'(64'hA500_0000_0000_0000) | DATA_W'(base + i), (i == len - 1), drop, tag);
  endtask

  // Downstream backpressure
  initial begin
    forever begin
      @(negedge clk);
      bp_cnt++;
      out_tready = !bp_en || (bp_cnt % 3 != 0);
    end
  end

  // Monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1.5;
      if (rvalid && rready) begin
        if (rd_exp_q.size() == 0) chk("R5 unexpected read data", 1, 0);
        else chk(rd_tag_q.pop_front(), rdata, rd_exp_q.pop_front());
      end
      if (out_tvalid && out_tready) begin
        if (st_exp_q.size() == 0) chk("R7 unexpected output beat", {out_tlast, out_tdata}, 0);
        else chk(st_tag_q.pop_front(), {out_tlast, out_tdata}, st_exp_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R1 outputs after reset
    chk("R1 reset outputs", {thresh, subcnt, gap, soft_rst}, {32'h1000, 16'd32, 32'd256, 1'b0});
    axil_read(8'h00, 32'h1000, "R1 threshold reset");
    axil_read(8'h04, 32'd32, "R1 count reset");
    axil_read(8'h08, 32'd256, "R1 gap reset");
    axil_read(8'hF8, 32'd0, "R1 drain reset");
    axil_read(8'hFC, 32'd0, "R1 hold reset");

    // R4 status word
    idle = 1;
    axil_read(8'h0C, 32'h21, "R4 status idle");
    idle = 0;
    axil_read(8'h0C, 32'h20, "R4 status busy");
    axil_write(8'h0C, 32'hFFFF_FFFF, 4'hF, "R4");
    axil_read(8'h0C, 32'h20, "R4 status after write");
    idle = 1;

    // R2 write and readback
    axil_write(8'h00, 32'h0000_BEEF, 4'hF, "R2");
    chk("R2 threshold output", thresh, 32'h0000_BEEF);
    axil_write(8'h04, 32'hABCD_1234, 4'hF, "R2");
    chk("R2 count output", subcnt, 16'h1234);
    axil_read(8'h04, 32'h0000_1234, "R2 count readback truncated");
    axil_write(8'h08, 32'h0000_0777, 4'hF, "R2");
    chk("R2 gap output", gap, 32'h777);

    // R3 byte strobes
    axil_write(8'h00, 32'h1122_3344, 4'hF, "R3");
    axil_write(8'h00, 32'hFFFF_FFFF, 4'b0010, "R3");
    axil_read(8'h00, 32'h1122_FF44, "R3 strobed lane");

    // R5 unmapped
    axil_read(8'h10, 32'd0, "R5 unmapped 0x10");
    axil_read(8'h40, 32'd0, "R5 unmapped 0x40");
    axil_write(8'h20, 32'hFFFF_FFFF, 4'hF, "R5");
    axil_read(8'h00, 32'h1122_FF44, "R5 threshold untouched");
    axil_read(8'h04, 32'h1234, "R5 count untouched");
    axil_read(8'h08, 32'h777, "R5 gap untouched");

    // R6 soft reset level
    axil_write(8'hFC, 32'h1, 4'hF, "R6");
    chk("R6 soft reset set", soft_rst, 1'b1);
    axil_read(8'hFC, 32'h1, "R6 soft reset readback");
    repeat (3) @(negedge clk);
    #1 chk("R6 soft reset held", soft_rst, 1'b1);
    axil_write(8'hFC, 32'h0, 4'hF, "R6");
    chk("R6 soft reset cleared", soft_rst, 1'b0);

    // R8 pass-through with backpressure
    bp_en = 1;
    send_frame(16'h100, 3, 0, "R8 frame A");
    send_frame(16'h200, 1, 0, "R8 frame B");
    send_frame(16'h300, 4, 0, "R8 frame C");

    // R7 drain while idle
    axil_write(8'hF8, 32'h1, 4'hF, "R7");
    axil_read(8'hF8, 32'h1, "R7 drain readback");
    send_frame(16'h400, 3, 1, "R7 drained frame");
    axil_write(8'hF8, 32'h0, 4'hF, "R7");
    send_frame(16'h500, 2, 0, "R8 after drain");

    // R9 drain requested mid-frame
    send_beat(64'hB0, 0, 0, "R9 head kept");
    axil_write(8'hF8, 32'h1, 4'hF, "R9");
    axil_read(8'hF8, 32'h1, "R9 request readback");
    send_beat(64'hB1, 0, 0, "R9 middle kept");
    send_beat(64'hB2, 1, 0, "R9 tail kept");
    send_frame(16'h600, 2, 1, "R9 next frame drained");
    // R9 drain released mid-frame
    send_beat(64'hC0, 0, 1, "R9 head dropped");
    axil_write(8'hF8, 32'h0, 4'hF, "R9");
    send_beat(64'hC1, 1, 1, "R9 tail dropped");
    send_frame(16'h700, 3, 0, "R9 resumed frame");

    bp_en = 0;
    repeat (20) @(negedge clk);
    chk("R8 all expected beats seen", st_exp_q.size(), 0);
    chk("R5 all expected reads seen", rd_exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule